// File: doc/BRIEF.md
# Low-Power and Auxiliary-Select Controller with Frame Tick

This block decides when a bus-powered audio device drops into its low-power state and when the auxiliary analog input is switched into the output mixer. It watches a host suspend indication, a cable-connected status and an active-low auxiliary-enable input. It drives a SUSPEND status pin, a select line for the mixer's auxiliary path, and an enable for the converter path that stays on at all times. Either a host suspend or a missing cable asks for low power. An active auxiliary-enable overrides that request, so an analog source stays audible with no host present.

A second function divides the 12 MHz reference clock into a 1 ms start-of-frame tick. Each frame marker seen on the bus restarts the divider, so the tick keeps phase with the host's frames. With no markers the divider runs free and the tick carries on.

The power state machine has three states. PS_NORMAL is full power with the auxiliary input off. PS_AUX has the auxiliary input selected and low power vetoed. PS_LOWPWR asserts SUSPEND. The transitions are evaluated every clock in this order: the synchronized auxiliary request moves any state to PS_AUX (aux_engage). Failing that, a sleep request (host suspend or no cable) moves any state to PS_LOWPWR (sleep_enter). Failing both, any state returns to PS_NORMAL (wake / aux_release).

Top module: `lpc_top`

## Requirements
- R1: While rst_n is low and on the first cycle after it is released, suspend_o, aux_sel_o and sof_o are 0 and the machine is in PS_NORMAL.
- R2: aux_en_n_i is active low. 0 requests the auxiliary input and 1 releases it. The input passes two synchronizer flops, so aux_sel_o follows a change on the third rising clock edge and not before.
- R3: dac_mix_en_o is 1 in every state, whatever the auxiliary setting or the power state.
- R4: With aux_en_n_i at 1 and usb_connected_i at 1, host_suspend_i at 1 sets suspend_o to 1 on the next rising edge.
- R5: With aux_en_n_i at 1, usb_connected_i at 0 sets suspend_o to 1 on the next rising edge, even when host_suspend_i is 0.
- R6: While the synchronized auxiliary request is active, suspend_o stays 0 even when host suspend or disconnect is present. An auxiliary request that arrives during low power pulls the block out of low power on the third edge.
- R7: Once no sleep request and no auxiliary request remain, suspend_o returns to 0 on the next rising edge.
- R8: Without frame markers, sof_o is a one-cycle pulse that repeats every 12000 clock cycles.
- R9: A one-cycle frame_mark_i produces an sof_o pulse on the next rising edge and restarts the period. The following pulse comes 12000 cycles later, and the old phase gives no pulse.
- R10: When the auxiliary request drops while a sleep request is present, suspend_o rises on the third edge after aux_en_n_i returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_suspend_i | input | 1 | Host has placed the bus in suspend (synchronous) |
| usb_connected_i | input | 1 | Cable/bus presence (synchronous) |
| aux_en_n_i | input | 1 | Auxiliary enable, active low, asynchronous |
| frame_mark_i | input | 1 | One-cycle strobe per received start-of-frame |
| suspend_o | output | 1 | 1 = low power, 0 = normal operation |
| aux_sel_o | output | 1 | 1 = auxiliary input switched into the mixer |
| dac_mix_en_o | output | 1 | Converter path into the mixer, always 1 |
| sof_o | output | 1 | 1 ms frame tick, one cycle wide |

## Verification
Changes on suspend request and cable status show up on suspend_o one rising edge later. A change on aux_en_n_i reaches aux_sel_o and suspend_o on the third edge, and the bench samples both the second and the third edge to catch a stage that is missing or extra. A frame marker driven for one cycle gives sof_o on the very next edge, and the bench then counts falling edges until the next pulse and expects exactly 12000. The bench drives every input on the falling edge and reads every output on a later falling edge, so each sample falls half a period after the register that produced it.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    // Power-manager states
    typedef enum logic [1:0] {
        PS_NORMAL = 2'd0,
        PS_AUX    = 2'd1,
        PS_LOWPWR = 2'd2
    } pwr_state_t;

    // 12 MHz reference divided down to a 1 ms frame
    localparam int unsigned FRAME_TICKS_DEF = 12000;
    localparam int unsigned SYNC_DEPTH_DEF  = 2;

endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lpc_frame_timer.sv
module lpc_frame_timer #(
    parameter int unsigned TICKS = lpc_pkg::FRAME_TICKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    output logic tick_o
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (mark_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    AST_MARK_GIVES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        mark_i |=> tick_o); // R9
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !mark_i) |=> !tick_o); // R8
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8

endmodule

// File: rtl/lpc_power_fsm.sv
module lpc_power_fsm
    import lpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_i,
    input  logic aux_req_i,
    output logic suspend_o,
    output logic aux_sel_o
);
    pwr_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_NORMAL;
        else        state_q <= state_d;
    end

    // Next state: aux request outranks sleep request
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_NORMAL: begin
                if (aux_req_i)        state_d = PS_AUX;      // aux_engage
                else if (sleep_req_i) state_d = PS_LOWPWR;   // sleep_enter
            end
            PS_AUX: begin
                if (!aux_req_i) begin
                    if (sleep_req_i)  state_d = PS_LOWPWR;   // sleep_enter
                    else              state_d = PS_NORMAL;   // aux_release
                end
            end
            PS_LOWPWR: begin
                if (aux_req_i)        state_d = PS_AUX;      // aux_engage
                else if (!sleep_req_i) state_d = PS_NORMAL;  // wake
            end
            default:                  state_d = PS_NORMAL;
        endcase
    end

    // Outputs
    always_comb begin
        suspend_o = 1'b0;
        aux_sel_o = 1'b0;
        unique case (state_q)
            PS_NORMAL: ;
            PS_AUX:    aux_sel_o = 1'b1;
            PS_LOWPWR: suspend_o = 1'b1;
            default:   ;
        endcase
    end

    AST_AUX_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        aux_req_i |=> (!suspend_o && aux_sel_o)); // R6
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req_i && !aux_req_i) |=> suspend_o); // R4
    AST_WAKE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req_i && !aux_req_i) |=> (!suspend_o && !aux_sel_o)); // R7
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({suspend_o, aux_sel_o})); // R6

endmodule

// File: rtl/lpc_top.sv
module lpc_top
    import lpc_pkg::*;
#(
    parameter int unsigned FRAME_TICKS = FRAME_TICKS_DEF,
    parameter int unsigned SYNC_DEPTH  = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_suspend_i,
    input  logic usb_connected_i,
    input  logic aux_en_n_i,
    input  logic frame_mark_i,
    output logic suspend_o,
    output logic aux_sel_o,
    output logic dac_mix_en_o,
    output logic sof_o
);
    logic aux_en_n_s;
    logic sleep_req;
    logic aux_req;

    lpc_sync #(
        .STAGES    (SYNC_DEPTH),
        .RESET_VAL (1'b1)
    ) u_aux_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (aux_en_n_i),
        .sync_o  (aux_en_n_s)
    );

    assign aux_req   = ~aux_en_n_s;
    assign sleep_req = host_suspend_i | ~usb_connected_i;

    lpc_power_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (sleep_req),
        .aux_req_i   (aux_req),
        .suspend_o   (suspend_o),
        .aux_sel_o   (aux_sel_o)
    );

    lpc_frame_timer #(
        .TICKS (FRAME_TICKS)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .mark_i (frame_mark_i),
        .tick_o (sof_o)
    );

    // Converter path into the mixer is never cut
    assign dac_mix_en_o = 1'b1;

    AST_DISCONNECT_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!usb_connected_i && aux_en_n_s) |=> suspend_o); // R5

endmodule

// File: tb/lpc_top_test.sv
module lpc_top_test;
    localparam int unsigned TICKS = 12000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_suspend_i = 1'b0;
    logic usb_connected_i = 1'b1;
    logic aux_en_n_i = 1'b1;
    logic frame_mark_i = 1'b0;
    logic suspend_o, aux_sel_o, dac_mix_en_o, sof_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lpc_top uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_suspend_i  (host_suspend_i),
        .usb_connected_i (usb_connected_i),
        .aux_en_n_i      (aux_en_n_i),
        .frame_mark_i    (frame_mark_i),
        .suspend_o       (suspend_o),
        .aux_sel_o       (aux_sel_o),
        .dac_mix_en_o    (dac_mix_en_o),
        .sof_o           (sof_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // pass n rising edges, land on the following falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "suspend in reset", suspend_o, 0);
        chk("R1", "aux_sel in reset", aux_sel_o, 0);
        chk("R1", "sof in reset", sof_o, 0);
        rst_n = 1'b1;
        edges(1);
        chk("R1", "suspend after reset", suspend_o, 0);
        chk("R1", "aux_sel after reset", aux_sel_o, 0);
        chk("R3", "dac path after reset", dac_mix_en_o, 1);
    endtask

    task automatic t_host_suspend();
        host_suspend_i = 1'b1;
        edges(1);
        chk("R4", "suspend on host request", suspend_o, 1);
        chk("R3", "dac path in low power", dac_mix_en_o, 1);
        host_suspend_i = 1'b0;
        edges(1);
        chk("R7", "wake after host resume", suspend_o, 0);
    endtask

    task automatic t_disconnect();
        usb_connected_i = 1'b0;
        edges(1);
        chk("R5", "suspend on disconnect", suspend_o, 1);
        usb_connected_i = 1'b1;
        edges(1);
        chk("R7", "wake on reconnect", suspend_o, 0);
    endtask

    task automatic t_aux_select();
        aux_en_n_i = 1'b0;
        edges(2);
        chk("R2", "aux_sel not before 3rd edge", aux_sel_o, 0);
        edges(1);
        chk("R2", "aux_sel on 3rd edge", aux_sel_o, 1);
        chk("R3", "dac path with aux", dac_mix_en_o, 1);
        aux_en_n_i = 1'b1;
        edges(2);
        chk("R2", "aux_sel held before 3rd edge", aux_sel_o, 1);
        edges(1);
        chk("R2", "aux_sel released", aux_sel_o, 0);
    endtask

    task automatic t_aux_veto();
        aux_en_n_i = 1'b0;
        edges(3);
        host_suspend_i = 1'b1;
        usb_connected_i = 1'b0;
        edges(4);
        chk("R6", "suspend vetoed by aux", suspend_o, 0);
        chk("R6", "aux_sel kept", aux_sel_o, 1);
        aux_en_n_i = 1'b1;
        edges(2);
        chk("R10", "suspend held off before 3rd edge", suspend_o, 0);
        edges(1);
        chk("R10", "suspend after aux release", suspend_o, 1);
        aux_en_n_i = 1'b0;
        edges(2);
        chk("R6", "still low power before 3rd edge", suspend_o, 1);
        edges(1);
        chk("R6", "aux pulls out of low power", suspend_o, 0);
        chk("R6", "aux selected from low power", aux_sel_o, 1);
        aux_en_n_i = 1'b1;
        host_suspend_i = 1'b0;
        usb_connected_i = 1'b1;
        edges(3);
        chk("R7", "normal after all cleared", suspend_o, 0);
    endtask

    task automatic wait_sof(output int n);
        n = 0;
        while (sof_o !== 1'b1 && n < 3 * TICKS) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_sof();
        int n;
        wait_sof(n);
        @(negedge clk);
        chk("R8", "sof is one cycle wide", sof_o, 0);
        n = 1;
        while (sof_o !== 1'b1 && n < 3 * TICKS) begin
            @(negedge clk);
            n++;
        end
        chk("R8", "free-running period", n, TICKS);
        // marker mid-frame
        repeat (5000) @(negedge clk);
        frame_mark_i = 1'b1;
        @(negedge clk);
        frame_mark_i = 1'b0;
        chk("R9", "sof right after marker", sof_o, 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sof_o !== 1'b1 && n < 3 * TICKS);
        chk("R9", "period restarts at marker", n, TICKS);
    endtask

    initial begin
        t_reset();
        t_host_suspend();
        t_disconnect();
        t_aux_select();
        t_aux_veto();
        t_sof();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule